// File: doc/BRIEF.md
# Sync Delay and Period Counter

This block generates the timing strobes used by a mixer's sync network. Two external sync inputs each pass through their own delay line. Each line adds a fixed two clocks plus a programmable 0 to 255 clocks, so every pulse pattern comes out unchanged, including pulses on consecutive cycles.

Beside the delay lines runs a free-running down-counter. Its period is programmable in steps of sixteen clocks, and it emits a one-clock terminal strobe each time it reaches zero. A small register port holds one 16-bit word with both delay amounts and one 16-bit period word. Both words are writable and read back at all times.

Top module: `syncTimer`

## Requirements
- R1: `dsa` equals `sa` delayed by 2 + delayA clocks, where delayA is bits 7:0 of the word at address 3. Every pulse pattern is reproduced, including pulses on consecutive cycles.
- R2: `dsb` equals `sb` delayed by 2 + delayB clocks, where delayB is bits 15:8 of the word at address 3.
- R3: After reset both delay fields read 0, the period word at address 4 reads 0x00FF, and `dsa`, `dsb` and `tc` are low.
- R4: The counter counts down from 16*P+15 to zero and then reloads, where P is the period word. Its period is therefore 16*(P+1) clocks, which is 4096 clocks for the reset value.
- R5: `tc` is high for exactly the one cycle in which the counter is zero.
- R6: A write to the period word at address 4 does not shorten the count in progress. The new value applies from the next reload on.
- R7: Reading address 3 returns {delayB, delayA}, and reading address 4 returns the period word. Every other address reads 0, and writes to other addresses change nothing.
- R8: A new delay value applies from the clock after the write. The output after clock edge k is the input sampled at edge k-1-d, where d is the delay value held just before edge k.
- R9: With a delay field at 255 a single pulse reappears 257 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| sa | input | 1 | Sync input A |
| sb | input | 1 | Sync input B |
| dsa | output | 1 | Delayed sync A |
| dsb | output | 1 | Delayed sync B |
| tc | output | 1 | Terminal-count strobe |

## Verification
The hardest case to reach is a delay change while pulses are still inside the line. The output then switches taps mid-stream, and only an exact cycle model can tell correct behaviour from a stale or off-by-one tap. The stimulus drives random sync streams, which include runs of consecutive pulses. It rewrites the delay word several times during those streams, and a history-based model that knows the delay in force at each edge checks both outputs on every cycle. The deferred period update is reached by writing the period word in the middle of the long default count and timing the two terminal strobes that follow.

// File: rtl/syncTimerPkg.sv
package syncTimerPkg;
  localparam int NUM_SYNC = 2;
  localparam int DLY_W    = 8;
  localparam int CNT_W    = 16;
  localparam int PRE_W    = 4;
  localparam int DATA_W   = 16;

  // Write strobes from control to the delay datapath
  typedef struct packed {
    logic [NUM_SYNC-1:0]            dlyLoad;
    logic [NUM_SYNC-1:0][DLY_W-1:0] dlyValue;
  } dlyCmd_t;
endpackage

// File: rtl/syncDelayPath.sv
module syncDelayPath
  import syncTimerPkg::*;
#(
  parameter int LINE_DEPTH = 2 ** DLY_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  dlyCmd_t                        cmd,
  input  logic [NUM_SYNC-1:0]            syncIn,
  output logic [NUM_SYNC-1:0]            syncOut,
  output logic [NUM_SYNC-1:0][DLY_W-1:0] dlyCur
);
  for (genvar c = 0; c < NUM_SYNC; c++) begin : gChan
    logic [LINE_DEPTH-1:0] line;
    logic [DLY_W-1:0]      dlyReg;
    logic                  outReg;

    always_ff @(posedge clk) begin
      if (rst) begin
        line   <= '0;
        dlyReg <= '0;
        outReg <= 1'b0;
      end else begin
        line   <= {line[LINE_DEPTH-2:0], syncIn[c]};
        outReg <= line[dlyReg];
        if (cmd.dlyLoad[c]) dlyReg <= cmd.dlyValue[c];
      end
    end

    assign syncOut[c] = outReg;
    assign dlyCur[c]  = dlyReg;
  end
endmodule

// File: rtl/syncCtrl.sv
module syncCtrl
  import syncTimerPkg::*;
#(
  parameter int               ADDR_W    = 3,
  parameter logic [CNT_W-1:0] COUNT_RST = 16'h00FF,
  parameter int               DLY_ADDR  = 3,
  parameter int               CNT_ADDR  = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  input  logic [NUM_SYNC-1:0][DLY_W-1:0] dlyCur,
  output dlyCmd_t                        cmd,
  output logic                           tc,
  output logic [CNT_W+PRE_W-1:0]         timerVal,
  output logic [CNT_W-1:0]               countCfg
);
  localparam int TIM_W = CNT_W + PRE_W;
  localparam logic [ADDR_W-1:0] DLY_SEL = ADDR_W'(DLY_ADDR);
  localparam logic [ADDR_W-1:0] CNT_SEL = ADDR_W'(CNT_ADDR);

  logic [CNT_W-1:0] countReg;
  logic [TIM_W-1:0] timer;
  logic             atZero;

  always_comb begin
    cmd.dlyLoad = {NUM_SYNC{wrEn && (addr == DLY_SEL)}};
    for (int c = 0; c < NUM_SYNC; c++)
      cmd.dlyValue[c] = wrData[c*DLY_W +: DLY_W];
  end

  assign atZero = (timer == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      countReg <= COUNT_RST;
      timer    <= {COUNT_RST, {PRE_W{1'b1}}};
    end else begin
      if (atZero) timer <= {countReg, {PRE_W{1'b1}}};
      else        timer <= timer - TIM_W'(1);
      if (wrEn && (addr == CNT_SEL)) countReg <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    if (addr == DLY_SEL)      rdData = DATA_W'(dlyCur);
    else if (addr == CNT_SEL) rdData = DATA_W'(countReg);
    else                      rdData = '0;
  end

  assign tc       = atZero;
  assign timerVal = timer;
  assign countCfg = countReg;
endmodule

// File: rtl/syncTimer.sv
module syncTimer
  import syncTimerPkg::*;
#(
  parameter int               ADDR_W    = 3,
  parameter logic [CNT_W-1:0] COUNT_RST = 16'h00FF,
  parameter int               DLY_ADDR  = 3,
  parameter int               CNT_ADDR  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic              sa,
  input  logic              sb,
  output logic              dsa,
  output logic              dsb,
  output logic              tc
);
  dlyCmd_t                        cmd;
  logic [NUM_SYNC-1:0][DLY_W-1:0] dlyCur;
  logic [NUM_SYNC-1:0]            syncOut;
  logic [CNT_W+PRE_W-1:0]         timerVal;
  logic [CNT_W-1:0]               countCfg;

  syncCtrl #(
    .ADDR_W(ADDR_W), .COUNT_RST(COUNT_RST),
    .DLY_ADDR(DLY_ADDR), .CNT_ADDR(CNT_ADDR)
  ) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .dlyCur(dlyCur), .cmd(cmd), .tc(tc),
    .timerVal(timerVal), .countCfg(countCfg)
  );

  syncDelayPath uPath (
    .clk(clk), .rst(rst), .cmd(cmd), .syncIn({sb, sa}),
    .syncOut(syncOut), .dlyCur(dlyCur)
  );

  assign dsa = syncOut[0];
  assign dsb = syncOut[1];
endmodule

// File: rtl/syncTimerChk.sv
module syncTimerChk
  import syncTimerPkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DLY_ADDR = 3,
  parameter int CNT_ADDR = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           wrEn,
  input logic [ADDR_W-1:0]              addr,
  input logic [15:0]                    wrData,
  input logic [15:0]                    rdData,
  input logic                           sa,
  input logic                           sb,
  input logic                           dsa,
  input logic                           dsb,
  input logic                           tc,
  input logic [CNT_W+PRE_W-1:0]         timerVal,
  input logic [CNT_W-1:0]               countCfg,
  input logic [NUM_SYNC-1:0][DLY_W-1:0] dlyCur
);
  localparam int TIM_W = CNT_W + PRE_W;
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_tc_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    tc |=> !tc);

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    tc |=> (timerVal == {$past(countCfg), {PRE_W{1'b1}}}));

  assert_countdown_R4: assert property (@(posedge clk) disable iff (rst)
    !tc |=> (timerVal == $past(timerVal) - TIM_W'(1)));

  assert_count_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == ADDR_W'(CNT_ADDR)) |=> (countCfg == $past(wrData)));

  assert_min_delay_a_R1: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(dlyCur[0]) == '0) |-> (dsa == $past(sa, 2)));

  assert_min_delay_b_R2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(dlyCur[1]) == '0) |-> (dsb == $past(sb, 2)));

  assert_unmapped_read_R7: assert property (@(posedge clk) disable iff (rst)
    (addr != ADDR_W'(DLY_ADDR) && addr != ADDR_W'(CNT_ADDR)) |-> (rdData == '0));
endmodule

bind syncTimer syncTimerChk #(
  .ADDR_W(ADDR_W), .DLY_ADDR(DLY_ADDR), .CNT_ADDR(CNT_ADDR)
) uChk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .sa(sa), .sb(sb), .dsa(dsa), .dsb(dsb), .tc(tc),
  .timerVal(timerVal), .countCfg(countCfg), .dlyCur(dlyCur)
);

// File: tb/tb_syncTimer.sv
module tb_syncTimer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, wrEn, sa, sb;
  logic [2:0]  addr;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        dsa, dsb, tc;

  int total = 0;
  int bad   = 0;

  syncTimer dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sa(sa), .sb(sb), .dsa(dsa), .dsb(dsb), .tc(tc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit   qa[$];
  bit   qb[$];
  bit   mDsa, mDsb, modelOn = 1'b0;
  int   mDlyA, mDlyB, mCount, mCnt;
  string tagA = "R1", tagB = "R2";

  always @(posedge clk) begin
    if (rst) begin
      qa.delete(); qb.delete();
      mDsa = 0; mDsb = 0; mDlyA = 0; mDlyB = 0;
      mCount = 255; mCnt = 16*255 + 15; modelOn = 1'b1;
    end else begin
      mDsa = (qa.size() > mDlyA) ? qa[qa.size()-1-mDlyA] : 1'b0;
      mDsb = (qb.size() > mDlyB) ? qb[qb.size()-1-mDlyB] : 1'b0;
      qa.push_back(sa); qb.push_back(sb);
      if (qa.size() > 300) begin void'(qa.pop_front()); void'(qb.pop_front()); end
      if (mCnt == 0) mCnt = 16*mCount + 15; else mCnt--;
      if (wrEn && addr == 3'd3) begin mDlyA = wrData[7:0]; mDlyB = wrData[15:8]; end
      if (wrEn && addr == 3'd4) mCount = wrData;
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      int expRd;
      check(tagA, dsa, mDsa);
      check(tagB, dsb, mDsb);
      check("R5", tc, mCnt == 0);
      expRd = (addr == 3'd3) ? (mDlyB*256 + mDlyA) : (addr == 3'd4) ? mCount : 0;
      check("R7", rdData, expRd);
    end
  end

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    step; wrEn = 1'b1; addr = a; wrData = d;
    step; wrEn = 1'b0;
  endtask

  task automatic randSync(input int n);
    repeat (n) begin
      step; sa = 1'($urandom); sb = 1'($urandom);
    end
  endtask

  task automatic measureTc(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tc);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; wrEn = 1'b0; addr = 3'd0; wrData = '0; sa = 1'b0; sb = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R3: reset state
    addr = 3'd3; @(negedge clk);
    check("R3", rdData, 0); check("R3", dsa, 0); check("R3", dsb, 0); check("R3", tc, 0);
    step; addr = 3'd4; @(negedge clk);
    check("R3", rdData, 16'h00FF);

    // R4: default period
    while (!tc) @(negedge clk);
    measureTc(n); check("R4", n, 4096);

    // R6: write mid-count, old period completes, new period follows
    n = 0;
    do begin
      step; n++;
      if (n == 5) begin wrEn = 1'b1; addr = 3'd4; wrData = 16'd2; end
      if (n == 6) wrEn = 1'b0;
      @(negedge clk);
    end while (!tc);
    check("R6", n, 4096);
    measureTc(n); check("R6", n, 48);
    measureTc(n); check("R4", n, 48);

    // R1/R2: random streams with back-to-back pulses
    writeReg(3'd3, {8'd17, 8'd5});
    randSync(600);
    writeReg(3'd3, 16'h0000);
    randSync(400);
    writeReg(3'd3, {8'd3, 8'd40});
    randSync(400);

    // R8: delay rewritten while pulses are in flight
    tagA = "R8"; tagB = "R8";
    for (int i = 0; i < 6; i++) begin
      step; wrEn = 1'b1; addr = 3'd3; wrData = 16'($urandom % 65536);
      sa = 1'($urandom); sb = 1'($urandom);
      randSync(120);
      wrEn = 1'b0;
    end
    wrEn = 1'b0;
    randSync(300);

    // R9: maximum delay
    tagA = "R9"; tagB = "R9";
    writeReg(3'd3, 16'hFFFF);
    step; sa = 1'b0; sb = 1'b0;
    repeat (300) step;
    sa = 1'b1; sb = 1'b1;
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      if (n == 1) begin sa = 1'b0; sb = 1'b0; end
      @(negedge clk);
    end while (!dsa && n < 400);
    check("R9", n, 257);
    check("R9", dsb, 1);
    randSync(600);

    // R7: unmapped address
    tagA = "R1"; tagB = "R2";
    writeReg(3'd5, 16'h1234);
    @(negedge clk); check("R7", rdData, 0);
    step; addr = 3'd3; @(negedge clk); check("R7", rdData, 16'hFFFF);
    step; addr = 3'd4; @(negedge clk); check("R7", rdData, 2);
    repeat (5) step;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule